// File: doc/BRIEF.md
# Extended-to-Single/Double Store Narrowing Converter

This block takes an 80-bit extended-precision value and narrows it to a 32-bit single or 64-bit double result, as a floating-point store path needs before it writes memory. It rebiases the exponent and rounds the significand under a 2-bit rounding mode. Zeros, infinities and NaNs are handled apart from the rounding path. Alongside the result it reports overflow, underflow, inexact and invalid, a round-up indicator (C1), and a store-enable. The store-enable drops when an unmasked exception means the destination must not be written.

One conversion is accepted per cycle through a valid/ready input stream and is presented one cycle later on a registered valid/ready output stream. Inputs are taken when `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and all status outputs hold unchanged. The extended input uses bit 79 as the sign, bits 78:64 as a 15-bit exponent with bias 16383, bit 63 as an explicit integer bit and bits 62:0 as the fraction.

Top module: `fpst_narrow`

## Requirements
- R1: After reset `out_valid`, `result`, `store_en` and all flags are 0. An accepted input appears on the outputs in the next cycle. A result held with `out_ready` low stays stable. `in_ready` equals `!out_valid || out_ready`.
- R2: A finite input within range is rebiased to the destination (single: 8-bit exponent, bias 127, 23 fraction bits; double: 11-bit exponent, bias 1023, 52 fraction bits), and an exact input gives no flags.
- R3: `rc` selects rounding when bits are discarded: 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R4: `flg_inx` is 1 when discarded bits are nonzero or overflow occurs. `c1` is 1 only when the delivered magnitude is larger than the input, and 0 whenever `flg_inx` is 0.
- R5: When the rounded exponent reaches the all-ones field, `flg_ovf` and `flg_inx` are set. The result is signed infinity for rc 00, for rc 01 with a negative sign and for rc 10 with a positive sign; otherwise it is the largest finite value of that sign.
- R6: `store_en` is 0 when overflow occurs with `mask_ovf` = 0 or invalid occurs with `mask_inv` = 0, and 1 otherwise.
- R7: A finite value whose exponent is below the destination minimum before rounding is tiny. It is encoded as a denormal, or as the minimum normal when rounding carries. `flg_unf` is set for a tiny value when it is inexact or `mask_unf` = 0.
- R8: Zero and infinity inputs give a zero or infinity of the same sign and raise no flag.
- R9: A quiet NaN (integer bit 1, fraction bit 62 = 1) keeps its sign. Its fraction is the top 23 or 52 input fraction bits, and it raises no flag.
- R10: A signalling NaN (exponent all ones, integer bit 1, bit 62 = 0, fraction nonzero) raises `flg_inv` alone. The output keeps the truncated fraction with the top fraction bit forced to 1.
- R11: An input with a nonzero exponent and integer bit 0 is unsupported. It raises `flg_inv` and gives the default NaN: sign 1, exponent all ones, only the top fraction bit set.
- R12: With `fmt_dbl` = 0 the single result sits in `result[31:0]` and `result[63:32]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Converter can take an input |
| x_in | input | 80 | Extended-precision value |
| fmt_dbl | input | 1 | 0 selects single, 1 selects double |
| rc | input | 2 | Rounding mode |
| mask_ovf | input | 1 | Overflow masked |
| mask_unf | input | 1 | Underflow masked |
| mask_inv | input | 1 | Invalid masked |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 64 | Narrowed value |
| store_en | output | 1 | Destination may be written |
| flg_ovf | output | 1 | Overflow |
| flg_unf | output | 1 | Underflow |
| flg_inx | output | 1 | Inexact |
| flg_inv | output | 1 | Invalid operation |
| c1 | output | 1 | Magnitude was rounded up |

## Verification
The assertions check, on every cycle, the properties that tie flags together or follow from the handshake. They cover output holding under back-pressure and loading after acceptance. They also check that C1 never appears without inexact, that overflow always brings inexact, and that an unmasked overflow or invalid never comes with a store. A masked underflow must carry inexact, invalid stands alone, and the upper word stays clear in single mode. The bench's scenarios are needed to show the actual rounded bit patterns. These include the tie cases, directed-rounding directions, the infinity-versus-largest-finite choice, denormal encodings and carries into the minimum normal, and the class-preserving treatment of zeros, infinities and NaNs. Those results can only be judged against an independently computed value.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
  localparam int XW    = 80;
  localparam int XEW   = 15;
  localparam int XMW   = 64;
  localparam int XBIAS = 16383;
  localparam int OUTW  = 64;
  localparam int NFMT  = 2;
  localparam int SGL_EW = 8;
  localparam int SGL_FW = 23;
  localparam int DBL_EW = 11;
  localparam int DBL_FW = 52;

  typedef enum logic [2:0] {
    CL_ZERO, CL_FIN, CL_INF, CL_QNAN, CL_SNAN, CL_UNSUP
  } fp_class_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00, RM_DOWN = 2'b01, RM_UP = 2'b10, RM_ZERO = 2'b11
  } rnd_mode_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic inx;
    logic inv;
    logic c1;
  } fp_flags_t;
endpackage

// File: rtl/fpst_classify.sv
module fpst_classify
  import fpst_pkg::*;
(
  input  logic [XEW-1:0] ex,
  input  logic [XMW-1:0] mant,
  output fp_class_e      cls
);
  logic           ibit;
  logic [XMW-2:0] frac;

  assign ibit = mant[XMW-1];
  assign frac = mant[XMW-2:0];

  always_comb begin
    if (ex == '1) begin
      if (!ibit)              cls = CL_UNSUP;
      else if (frac == '0)    cls = CL_INF;
      else if (frac[XMW-2])   cls = CL_QNAN;
      else                    cls = CL_SNAN;
    end else if (ex == '0) begin
      cls = (mant == '0) ? CL_ZERO : CL_FIN;
    end else begin
      cls = ibit ? CL_FIN : CL_UNSUP;
    end
  end
endmodule

// File: rtl/fpst_round.sv
module fpst_round
  import fpst_pkg::*;
#(
  parameter  int EW = 8,
  parameter  int FW = 23,
  localparam int RW = 1 + EW + FW
) (
  input  logic           sgn,
  input  logic [XEW-1:0] ex,
  input  logic [XMW-1:0] mant,
  input  fp_class_e      cls,
  input  rnd_mode_e      rc,
  input  logic           mask_unf,
  output logic [RW-1:0]  res,
  output fp_flags_t      fl
);
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int EALL = (1 << EW) - 1;
  localparam int TW   = XEW + 3;
  localparam int SHW  = $clog2(XMW) + 1;
  localparam logic signed [TW-1:0] REBIAS = TW'(BIAS - XBIAS);

  logic [XEW-1:0]        eff;
  logic signed [TW-1:0]  te, te_r;
  logic                  tiny;
  logic [TW-1:0]         shn;
  logic [SHW-1:0]        sh;
  logic [XMW-1:0]        msh, lmask;
  logic                  lost, grd, stk, inx_r, inc, ovf_c, to_inf;
  logic [FW:0]           kept;
  logic [FW+1:0]         rnd;
  logic [FW-1:0]         frac_n;

  // exponent rebias and denormalising shift
  always_comb begin
    eff   = (ex == '0) ? XEW'(1) : ex;
    te    = $signed({3'b000, eff}) + REBIAS;
    tiny  = te[TW-1] || (te == '0);
    shn   = tiny ? (TW'(1) - $unsigned(te)) : '0;
    sh    = (shn >= TW'(XMW)) ? SHW'(XMW) : shn[SHW-1:0];
    msh   = (sh >= SHW'(XMW)) ? '0 : (mant >> sh);
    lmask = (sh >= SHW'(XMW)) ? '1 : ((XMW'(1) << sh) - XMW'(1));
    lost  = |(mant & lmask);
  end

  // significand rounding
  always_comb begin
    kept  = msh[XMW-1 -: FW+1];
    grd   = msh[XMW-2-FW];
    stk   = lost || (|msh[XMW-3-FW:0]);
    inx_r = grd || stk;
    unique case (rc)
      RM_NEAR: inc = grd && (stk || kept[0]);
      RM_DOWN: inc = inx_r && sgn;
      RM_UP:   inc = inx_r && !sgn;
      default: inc = 1'b0;
    endcase
    rnd    = {1'b0, kept} + (FW+2)'(inc);
    te_r   = te + $signed({{(TW-1){1'b0}}, rnd[FW+1]});
    ovf_c  = !tiny && (te_r >= $signed(TW'(EALL)));
    to_inf = (rc == RM_NEAR) || (rc == RM_DOWN && sgn) || (rc == RM_UP && !sgn);
    frac_n = rnd[FW+1] ? '0 : rnd[FW-1:0];
  end

  // result assembly per class
  always_comb begin
    fl  = '0;
    res = '0;
    unique case (cls)
      CL_ZERO:  res = {sgn, {(RW-1){1'b0}}};
      CL_INF:   res = {sgn, {EW{1'b1}}, {FW{1'b0}}};
      CL_QNAN:  res = {sgn, {EW{1'b1}}, mant[XMW-2 -: FW]};
      CL_SNAN: begin
        res    = {sgn, {EW{1'b1}}, 1'b1, mant[XMW-3 -: FW-1]};
        fl.inv = 1'b1;
      end
      CL_UNSUP: begin
        res    = {1'b1, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
        fl.inv = 1'b1;
      end
      default: begin
        if (ovf_c) begin
          fl.ovf = 1'b1;
          fl.inx = 1'b1;
          fl.c1  = to_inf;
          res    = to_inf ? {sgn, {EW{1'b1}}, {FW{1'b0}}}
                          : {sgn, EW'(EALL - 1), {FW{1'b1}}};
        end else begin
          fl.inx = inx_r;
          fl.c1  = inc;
          fl.unf = tiny && (inx_r || !mask_unf);
          if (tiny) res = {sgn, {(EW-1){1'b0}}, rnd[FW], rnd[FW-1:0]};
          else      res = {sgn, te_r[EW-1:0], frac_n};
        end
      end
    endcase
  end
endmodule

// File: rtl/fpst_narrow.sv
module fpst_narrow
  import fpst_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XW-1:0]   x_in,
  input  logic            fmt_dbl,
  input  logic [1:0]      rc,
  input  logic            mask_ovf,
  input  logic            mask_unf,
  input  logic            mask_inv,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OUTW-1:0] result,
  output logic            store_en,
  output logic            flg_ovf,
  output logic            flg_unf,
  output logic            flg_inx,
  output logic            flg_inv,
  output logic            c1
);
  fp_class_e       cls;
  logic [OUTW-1:0] res_g [NFMT];
  fp_flags_t       fl_g  [NFMT];
  logic [OUTW-1:0] res_sel;
  fp_flags_t       fl_sel;
  logic            st_sel;

  fpst_classify u_cls (
    .ex   (x_in[XW-2 -: XEW]),
    .mant (x_in[XMW-1:0]),
    .cls  (cls)
  );

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    localparam int EW = (g == 1) ? DBL_EW : SGL_EW;
    localparam int FW = (g == 1) ? DBL_FW : SGL_FW;
    localparam int RW = 1 + EW + FW;
    logic [RW-1:0] rw;

    fpst_round #(.EW(EW), .FW(FW)) u_rnd (
      .sgn      (x_in[XW-1]),
      .ex       (x_in[XW-2 -: XEW]),
      .mant     (x_in[XMW-1:0]),
      .cls      (cls),
      .rc       (rnd_mode_e'(rc)),
      .mask_unf (mask_unf),
      .res      (rw),
      .fl       (fl_g[g])
    );
    assign res_g[g] = OUTW'(rw);
  end

  always_comb begin
    res_sel = fmt_dbl ? res_g[1] : res_g[0];
    fl_sel  = fmt_dbl ? fl_g[1]  : fl_g[0];
    st_sel  = !(fl_sel.ovf && !mask_ovf) && !(fl_sel.inv && !mask_inv);
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      store_en  <= 1'b0;
      flg_ovf   <= 1'b0;
      flg_unf   <= 1'b0;
      flg_inx   <= 1'b0;
      flg_inv   <= 1'b0;
      c1        <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) begin
        result   <= res_sel;
        store_en <= st_sel;
        flg_ovf  <= fl_sel.ovf;
        flg_unf  <= fl_sel.unf;
        flg_inx  <= fl_sel.inx;
        flg_inv  <= fl_sel.inv;
        c1       <= fl_sel.c1;
      end
    end
  end
endmodule

// File: rtl/fpst_narrow_chk.sv
module fpst_narrow_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        fmt_dbl,
  input logic        mask_ovf,
  input logic        mask_unf,
  input logic        mask_inv,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] result,
  input logic        store_en,
  input logic        flg_ovf,
  input logic        flg_unf,
  input logic        flg_inx,
  input logic        flg_inv,
  input logic        c1
);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(store_en) && $stable(flg_inx));

  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r4_c1_needs_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && c1 |-> flg_inx);

  a_r5_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flg_ovf |-> flg_inx);

  a_r6_ovf_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !mask_ovf |=> !(flg_ovf && store_en));

  a_r6_inv_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !mask_inv |=> !(flg_inv && store_en));

  a_r7_unf_masked: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && mask_unf |=> !flg_unf || flg_inx);

  a_r10_inv_alone: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flg_inv |-> !flg_ovf && !flg_unf && !flg_inx && !c1);

  a_r12_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !fmt_dbl |=> result[63:32] == 32'h0);
endmodule

bind fpst_narrow fpst_narrow_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .fmt_dbl(fmt_dbl), .mask_ovf(mask_ovf), .mask_unf(mask_unf), .mask_inv(mask_inv),
  .out_valid(out_valid), .out_ready(out_ready), .result(result), .store_en(store_en),
  .flg_ovf(flg_ovf), .flg_unf(flg_unf), .flg_inx(flg_inx), .flg_inv(flg_inv), .c1(c1)
);

// File: tb/fpst_narrow_test.sv
module fpst_narrow_test;
  localparam int CLK_NS = 10;
  localparam logic [63:0] ONE = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [79:0] x_in = '0;
  logic        fmt_dbl = 1'b0;
  logic [1:0]  rc = 2'b00;
  logic        mask_ovf = 1'b1, mask_unf = 1'b1, mask_inv = 1'b1;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] result;
  logic        store_en, flg_ovf, flg_unf, flg_inx, flg_inv, c1;

  fpst_narrow uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .x_in(x_in),
    .fmt_dbl(fmt_dbl), .rc(rc), .mask_ovf(mask_ovf), .mask_unf(mask_unf),
    .mask_inv(mask_inv), .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .store_en(store_en), .flg_ovf(flg_ovf), .flg_unf(flg_unf), .flg_inx(flg_inx),
    .flg_inv(flg_inv), .c1(c1)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit exp_full = 1'b0;
  bit stall_en = 1'b1;
  bit last_acc = 1'b0;
  string cur_tag = "";
  logic [69:0] expq[$];
  string       tagq[$];

  task automatic chk(input bit ok, input string tag, input logic [69:0] act, input logic [69:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [79:0] mk(input logic s, input int e, input logic [63:0] m);
    return {s, e[14:0], m};
  endfunction

  function automatic logic [63:0] pack(input logic dbl, input logic s, input longint ef, input logic [127:0] fr);
    if (dbl) return {s, ef[10:0], fr[51:0]};
    return {32'h0, s, ef[7:0], fr[22:0]};
  endfunction

  // behavioural reference: value = M * 2^(e-63); drop bits below the destination ulp
  function automatic logic [69:0] model(input logic [79:0] x, input logic dbl, input logic [1:0] m_rc,
                                        input logic mo, input logic mu, input logic mi);
    int F, B, EM, E, e, ulp, n;
    logic s, ovf, unf, inx, inv, cu, up, gt, eq, nz, tiny, toinf, st;
    logic [63:0] M, r;
    logic [127:0] q, R, H, W;
    longint ef;
    F = dbl ? 52 : 23; B = dbl ? 1023 : 127; EM = dbl ? 2047 : 255;
    s = x[79]; E = int'(x[78:64]); M = x[63:0];
    ovf = 0; unf = 0; inx = 0; inv = 0; cu = 0; r = '0;
    if (E != 0 && !M[63]) begin
      inv = 1; r = pack(dbl, 1'b1, longint'(EM), 128'd1 << (F-1));
    end else if (E == 32767) begin
      if (M[62:0] == 0) r = pack(dbl, s, longint'(EM), 128'd0);
      else if (M[62]) r = pack(dbl, s, longint'(EM), {65'd0, M[62:0]} >> (63-F));
      else begin
        inv = 1; r = pack(dbl, s, longint'(EM), ({65'd0, M[62:0]} >> (63-F)) | (128'd1 << (F-1)));
      end
    end else if (M == 0) begin
      r = pack(dbl, s, 0, 128'd0);
    end else begin
      e = ((E == 0) ? 1 : E) - 16383;
      tiny = (e < 1 - B);
      ulp = ((e > 1 - B) ? e : 1 - B) - F;
      n = ulp - e + 63;
      W = {64'd0, M};
      if (n >= 65) begin
        q = 0; gt = 0; eq = 0; nz = (M != 0);
      end else begin
        q = W >> n; R = W & ((128'd1 << n) - 1); H = 128'd1 << (n-1);
        gt = R > H; eq = R == H; nz = R != 0;
      end
      case (m_rc)
        2'b00: up = gt || (eq && q[0]);
        2'b01: up = nz && s;
        2'b10: up = nz && !s;
        default: up = 0;
      endcase
      q = q + {127'd0, up};
      if (q == (128'd1 << (F+1))) begin q = q >> 1; ulp++; end
      if (q >= (128'd1 << F)) begin ef = longint'(ulp + F + B); q = q - (128'd1 << F); end
      else ef = 0;
      inx = nz; cu = up;
      if (ef >= longint'(EM)) begin
        ovf = 1; inx = 1;
        toinf = (m_rc == 2'b00) || (m_rc == 2'b01 && s) || (m_rc == 2'b10 && !s);
        cu = toinf;
        r = toinf ? pack(dbl, s, longint'(EM), 128'd0)
                  : pack(dbl, s, longint'(EM-1), (128'd1 << F) - 1);
      end else begin
        unf = tiny && (mu ? nz : 1'b1);
        r = pack(dbl, s, ef, q);
      end
    end
    st = !(ovf && !mo) && !(inv && !mi);
    return {st, ovf, unf, inx, inv, cu, r};
  endfunction

  // one cycle, entered just after a falling edge
  task automatic cycle();
    logic [69:0] act;
    bit acc;
    out_ready = stall_en ? ($urandom_range(0, 3) != 0) : 1'b1;
    #1;
    act = {store_en, flg_ovf, flg_unf, flg_inx, flg_inv, c1, result};
    chk(out_valid === exp_full, "R1 out_valid", 70'(out_valid), 70'(exp_full));
    chk(in_ready === (!exp_full || out_ready), "R1 in_ready", 70'(in_ready), 70'(!exp_full || out_ready));
    if (exp_full) begin
      chk(act === expq[0], tagq[0], act, expq[0]);
      if (out_ready) begin void'(expq.pop_front()); void'(tagq.pop_front()); end
    end
    acc = in_valid && (!exp_full || out_ready);
    if (acc) begin
      expq.push_back(model(x_in, fmt_dbl, rc, mask_ovf, mask_unf, mask_inv));
      tagq.push_back(cur_tag);
    end
    exp_full = acc ? 1'b1 : (exp_full && !out_ready);
    last_acc = acc;
    @(negedge clk);
  endtask

  task automatic send(input logic [79:0] x, input logic dbl, input logic [1:0] m_rc,
                      input logic mo, input logic mu, input logic mi, input string tag);
    x_in = x; fmt_dbl = dbl; rc = m_rc; mask_ovf = mo; mask_unf = mu; mask_inv = mi;
    cur_tag = tag; in_valid = 1'b1;
    do cycle(); while (!last_acc);
    in_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid === 1'b0 && result === 64'h0 && store_en === 1'b0 && flg_inx === 1'b0,
        "R1 reset state", {store_en, flg_ovf, flg_unf, flg_inx, flg_inv, c1, result}, 70'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2, R12: exact conversions
    send(mk(0, 16383, ONE), 0, 0, 1, 1, 1, "R12 R2 one single");
    send(mk(0, 16383, ONE), 1, 0, 1, 1, 1, "R2 one double");
    send(mk(1, 16393, 64'hC000_0000_0000_0000), 1, 0, 1, 1, 1, "R2 -1536 double");
    send(mk(1, 16393, 64'hC000_0000_0000_0000), 0, 0, 1, 1, 1, "R12 -1536 single");
    // R3, R4: ties and directed modes
    send(mk(0, 16383, ONE | (64'd1 << 39)), 0, 0, 1, 1, 1, "R3 tie to even down");
    send(mk(0, 16383, ONE | (64'd1 << 40) | (64'd1 << 39)), 0, 0, 1, 1, 1, "R3 tie to even up");
    for (int m = 0; m < 4; m++) begin
      send(mk(1, 16383, ONE | (64'd1 << 39) | (64'd1 << 23)), 0, 2'(m), 1, 1, 1, "R3 R4 neg modes");
      send(mk(0, 16383, ONE | (64'd1 << 5)), 1, 2'(m), 1, 1, 1, "R4 pos double modes");
    end
    // R5, R6: overflow
    for (int m = 0; m < 4; m++) begin
      send(mk(0, 16383 + 200, ONE), 0, 2'(m), 1, 1, 1, "R5 ovf pos");
      send(mk(1, 16383 + 1100, ONE), 1, 2'(m), 1, 1, 1, "R5 ovf neg double");
    end
    send(mk(0, 16383 + 127, 64'hFFFF_FFFF_FFFF_FFFF), 0, 0, 1, 1, 1, "R5 rounding carry to inf");
    send(mk(0, 16383 + 127, 64'hFFFF_FFFF_FFFF_FFFF), 0, 3, 1, 1, 1, "R4 truncate to max no ovf");
    send(mk(0, 16383 + 200, ONE), 0, 0, 0, 1, 1, "R6 unmasked ovf no store");
    send(mk(0, 16383 + 200, ONE), 0, 0, 1, 1, 0, "R6 masked ovf stores");
    send(mk(0, 32767, ONE | 64'd5), 1, 0, 1, 1, 0, "R6 unmasked invalid no store");
    // R7: tiny values
    send(mk(0, 16383 - 130, ONE), 0, 0, 1, 1, 1, "R7 exact tiny masked");
    send(mk(0, 16383 - 130, ONE), 0, 0, 1, 0, 1, "R7 exact tiny unmasked");
    send(mk(0, 16383 - 140, ONE | 64'd1), 0, 2, 1, 1, 1, "R7 inexact tiny up");
    send(mk(1, 16383 - 140, ONE | 64'd1), 0, 0, 1, 1, 1, "R7 inexact tiny near");
    send(mk(0, 16383 - 127, 64'hFFFF_FFFF_FFFF_FFFF), 0, 0, 1, 1, 1, "R7 carry to min normal");
    send(mk(0, 16383 - 1060, ONE | (64'd1 << 20)), 1, 0, 1, 1, 1, "R7 double denormal");
    send(mk(0, 0, 64'd1), 0, 2, 1, 1, 1, "R7 extended denormal up");
    send(mk(0, 0, 64'd1), 1, 0, 1, 1, 1, "R7 extended denormal near");
    // R8 to R11: specials in both formats
    for (int d = 0; d < 2; d++) begin
      send(mk(0, 0, 64'd0), 1'(d), 2, 1, 1, 1, "R8 +zero");
      send(mk(1, 0, 64'd0), 1'(d), 1, 1, 1, 1, "R8 -zero");
      send(mk(0, 32767, ONE), 1'(d), 3, 1, 1, 1, "R8 +inf");
      send(mk(1, 32767, ONE), 1'(d), 0, 1, 1, 1, "R8 -inf");
      send(mk(1, 32767, 64'hC123_4567_89AB_CDEF), 1'(d), 0, 1, 1, 1, "R9 qnan");
      send(mk(0, 32767, 64'h8765_4321_0FED_CBA9), 1'(d), 0, 1, 1, 1, "R10 snan quieted");
      send(mk(0, 32767, ONE | 64'd1), 1'(d), 0, 1, 1, 1, "R10 snan low bit only");
      send(mk(0, 16400, 64'h4000_0000_0000_0000), 1'(d), 0, 1, 1, 1, "R11 unnormal");
      send(mk(0, 32767, 64'd0), 1'(d), 0, 1, 1, 1, "R11 pseudo infinity");
    end
    // random mix across the ranges
    for (int i = 0; i < 400; i++) begin
      int e;
      logic [63:0] m;
      e = 16383 + int'($urandom_range(0, 2600)) - 1300;
      m = {1'b1, 31'($urandom), $urandom};
      if (i % 3 == 0) m[30:0] = '0;
      send(mk(1'($urandom), e, m), 1'($urandom), 2'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), "random R2 R3 R5 R7");
    end

    stall_en = 1'b0;
    repeat (4) cycle();
    chk(expq.size() == 0, "R1 drained", 70'(expq.size()), 70'd0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule